// File: doc/BRIEF.md
# Next Instruction Address Unit

This block holds the program counter of a single-cycle 32-bit core and works out the address of the next instruction. Each cycle it takes the fetched instruction word, the decoded branch and jump controls and the zero flag from the ALU. From these it selects one of three successors: the sequential address, a conditional PC-relative branch target, or an absolute jump target inside the current 256 MB region.

The program counter register is part of the block. It loads the chosen successor on every rising clock edge and has no enable input. A synchronous reset clears it. The incremented address is also driven out, for use as a link value and for debug. The combinational next address is visible at the same time as the current PC, so the fetch stage and the branch resolution stay inside one cycle.

Top module: `next_pc_unit`

## Requirements
- R1: After a clock edge with `rst` high, `pc` equals 0x00000000.
- R2: `pc_plus4` always equals `pc + 4` modulo 2^32.
- R3: With neither `jump` nor a taken branch, `next_pc` equals `pc_plus4` and `pc` takes that value at the next edge.
- R4: A branch is taken only when `branch` and `zero` are both 1. The target is then `pc_plus4 + (sign_extend(instr[15:0]) << 2)`.
- R5: When `branch` is 1 and `zero` is 0, the branch has no effect and `next_pc` equals `pc_plus4`.
- R6: When `jump` is 1, `next_pc` equals `{pc_plus4[31:28], instr[25:0], 2'b00}`.
- R7: `jump` takes priority over a taken branch when both are asserted.
- R8: Negative branch offsets, and increments past 0xFFFFFFFC, wrap in 32-bit two's complement.
- R9: `pc` loads `next_pc` on every rising edge when not in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Current instruction word |
| branch | input | 1 | Decoded conditional-branch control |
| jump | input | 1 | Decoded jump control |
| zero | input | 1 | ALU zero flag, high when the operands are equal |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential successor address |
| next_pc | output | 32 | Address loaded at the next edge |

## Verification
A jump and a taken branch can both be requested in the same cycle. A correct decoder never does this, but the selector must still resolve it. The bench provokes the case with directed cycles that raise `jump`, `branch` and `zero` together, and it also lets random stimulus hit the combination. It judges the result by requiring the jump target on `next_pc` and in `pc` after the edge. The second case puts both targets in the same cycle with a jump field and a branch offset that point to different addresses, so any mix-up is seen. Wrap behaviour is covered by starting from a jump to the top of the region and by using large negative offsets.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int JFIELD_W = 26,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] instr,
  input  logic            branch,
  input  logic            jump,
  input  logic            zero,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] pc_plus4,
  output logic [XLEN-1:0] next_pc
);
  localparam int REGION_W = XLEN - JFIELD_W - 2;

  logic [XLEN-1:0] offset_words;
  logic [XLEN-1:0] branch_tgt;
  logic [XLEN-1:0] jump_tgt;
  logic            take_branch;

  assign pc_plus4     = pc + XLEN'(4);
  assign offset_words = {{(XLEN-IMM_W-2){instr[IMM_W-1]}}, instr[IMM_W-1:0], 2'b00};
  assign branch_tgt   = pc_plus4 + offset_words;
  assign jump_tgt     = {pc_plus4[XLEN-1 -: REGION_W], instr[JFIELD_W-1:0], 2'b00};
  assign take_branch  = branch & zero;

  always_comb begin
    if (jump)             next_pc = jump_tgt;
    else if (take_branch) next_pc = branch_tgt;
    else                  next_pc = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= next_pc;
  end

  a_r1_reset_value: assert property (@(posedge clk) rst |=> pc == RESET_PC);
  a_r9_pc_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc == $past(next_pc));
  a_r5_not_taken: assert property (@(posedge clk) disable iff (rst)
    (branch && !zero && !jump) |-> next_pc == pc_plus4);
  a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
    (!branch && !jump) |=> pc == $past(pc) + XLEN'(4));
  a_r6_jump_region: assert property (@(posedge clk) disable iff (rst)
    jump |-> (next_pc[XLEN-1 -: REGION_W] == pc_plus4[XLEN-1 -: REGION_W]) && (next_pc[1:0] == 2'b00));
  a_r2_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc[1:0] == 2'b00);
endmodule

// File: tb/next_pc_unit_test.sv
module next_pc_unit_test;
  logic        clk = 0;
  logic        rst;
  logic [31:0] instr;
  logic        branch, jump, zero;
  logic [31:0] pc, pc_plus4, next_pc;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  next_pc_unit uut (.clk(clk), .rst(rst), .instr(instr), .branch(branch),
    .jump(jump), .zero(zero), .pc(pc), .pc_plus4(pc_plus4), .next_pc(next_pc));

  function automatic logic [31:0] exp_next(input logic [31:0] p, input logic [31:0] i,
      input logic b, input logic j, input logic z);
    logic [31:0] s;
    s = p + 32'd4;
    if (j) return {s[31:28], i[25:0], 2'b00};
    if (b && z) return s + {{14{i[15]}}, i[15:0], 2'b00};
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [31:0] i, input logic b,
      input logic j, input logic z);
    logic [31:0] p0, e;
    instr = i; branch = b; jump = j; zero = z;
    #1;
    p0 = pc;
    e = exp_next(p0, i, b, j, z);
    check("R2", pc_plus4, p0 + 32'd4);
    check(req, next_pc, e);
    @(posedge clk); #1;
    check("R9", pc, e);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; instr = 0; branch = 0; jump = 0; zero = 0;
    @(posedge clk); @(posedge clk); #1;
    check("R1", pc, 32'h0);
    rst = 0;
    step("R3", 32'h1234_5678, 0, 0, 1);
    step("R3", 32'hFFFF_FFFF, 0, 0, 0);
    step("R4", 32'h0000_0010, 1, 0, 1);
    step("R5", 32'h0000_0010, 1, 0, 0);
    step("R8", 32'h0000_FFFF, 1, 0, 1);
    step("R8", 32'h0000_8000, 1, 0, 1);
    step("R6", 32'h0BAD_CAFE, 0, 1, 0);
    step("R7", 32'h0000_0100, 1, 1, 1);
    step("R6", 32'h03FF_FFFF, 0, 1, 0);
    step("R8", 32'h0, 0, 0, 0);
    step("R6", 32'h0000_0001, 0, 1, 0);
    step("R7", 32'h0200_7FFF, 1, 1, 1);
    void'($urandom(32'd77));
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      step("R7", $urandom, r[0], r[1] & r[2] & r[3], r[4]);
    end
    rst = 1; @(posedge clk); #1;
    check("R1", pc, 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule